// File: doc/BRIEF.md
# Host Byte Mailbox

The block is a two-way byte mailbox between an asynchronous host bus and an embedded controller, in the style of a keyboard-controller port. The host sees a chip select, one address bit, separate active-low read and write strobes and an 8-bit data bus. The controller sees a synchronous register port clocked by `clk_i`.

A host write fills an inbound byte register and raises an inbound-full flag. The address bit of that write is kept as a command/data tag. A controller write fills an outbound byte register and raises an outbound-full flag. Each side clears the flag that the other side raised by consuming the byte. Both flags are also driven as level interrupt requests to the controller.

Host strobes and bus lines are brought into the controller clock through a two-flop synchronizer. A host access takes effect when its strobe is released. The flags change on the third rising clock edge after the release.

Top module: `host_mbox`

## Requirements
- R1: After reset the status byte reads 0x00, both interrupt outputs are low and the outbound register reads 0x00.
- R2: A host write is a low pulse on `host_wr_ni` while `host_cs_ni` is low. It loads `host_d_i` into the inbound register, which the controller reads at slave address 0. A write strobe while chip select is high has no effect.
- R3: Status bit 3 takes the level of `host_a0_i` from the most recent completed host write. 1 marks a command and 0 marks data.
- R4: Inbound-full (status bit 1) sets on the third rising clock edge after a host write strobe is released. A second host write before the controller reads overwrites the byte, and the flag stays set.
- R5: A controller read strobe (`sl_re_i`) at slave address 0 clears inbound-full at that clock edge.
- R6: A controller write (`sl_we_i`) at slave address 1 loads the outbound register and sets outbound-full (status bit 0) at that clock edge.
- R7: A host read is a low pulse on `host_rd_ni` while `host_cs_ni` is low. A host read with `host_a0_i` low clears outbound-full on the third rising edge after release. A host read with `host_a0_i` high does not clear it.
- R8: A controller write at slave address 2 with data bit 0 low clears outbound-full. With data bit 0 high it leaves the flag unchanged.
- R9: When a set event and a clear event for the same flag fall on the same clock edge, the flag ends up set.
- R10: During a host read, `host_d_oe_o` is high. `host_d_o` returns the outbound register when `host_a0_i` is 0 and the status byte when it is 1. Status bits 2 and 7..4 read 0. Slave address 2 also returns the status byte.
- R11: `ibf_irq_o` equals inbound-full and `obf_irq_o` equals outbound-full at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_cs_ni | input | 1 | Host chip select, active low |
| host_a0_i | input | 1 | Host address bit (command/data, register select) |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_d_i | input | 8 | Host write data |
| host_d_o | output | 8 | Host read data |
| host_d_oe_o | output | 1 | Host data bus drive enable |
| sl_re_i | input | 1 | Controller read strobe |
| sl_we_i | input | 1 | Controller write strobe |
| sl_addr_i | input | 2 | Controller register select: 0 inbound, 1 outbound, 2 status |
| sl_wdata_i | input | 8 | Controller write data |
| sl_rdata_o | output | 8 | Controller read data |
| ibf_irq_o | output | 1 | Inbound-full request |
| obf_irq_o | output | 1 | Outbound-full request |

## Verification
The hardest case to reach is a set event and a clear event on the same flag at one clock edge. A host access only takes effect three edges after its strobe is released, so the controller strobe has to be placed on exactly that edge. The stimulus releases the host strobe on a falling clock edge, waits two more falling edges, and then pulses the controller read or write. This collides an inbound set with a controller read, and an outbound clear from the host with a controller write. The reference model applies host events with the same three-edge delay and is compared on every cycle.

// File: rtl/host_mbox_pkg.sv
package host_mbox_pkg;
  localparam int OBF_BIT = 0;
  localparam int IBF_BIT = 1;
  localparam int CD_BIT  = 3;

  typedef enum logic [1:0] {
    SA_IDR = 2'd0,
    SA_ODR = 2'd1,
    SA_STS = 2'd2
  } sl_addr_e;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[g] <= '0;
      else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          a0_i,
  input  logic          wr_ni,
  input  logic          rd_ni,
  input  logic [DW-1:0] d_i,
  output logic          wr_done_o,
  output logic          rd_done_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_a0_o,
  output logic          rd_a0_o
);
  localparam int SW = DW + 3;

  logic [SW-1:0] raw, syn;
  logic          wr_s, rd_s, a0_s, wr_q, rd_q;
  logic [DW-1:0] d_s;

  assign raw = {~cs_ni & ~wr_ni, ~cs_ni & ~rd_ni, a0_i, d_i};

  mbox_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {wr_s, rd_s, a0_s, d_s} = syn;

  // keep the last bus values seen while a strobe was active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      wr_data_o <= '0;
      wr_a0_o   <= 1'b0;
      rd_a0_o   <= 1'b0;
    end else begin
      wr_q <= wr_s;
      rd_q <= rd_s;
      if (wr_s) begin
        wr_data_o <= d_s;
        wr_a0_o   <= a0_s;
      end
      if (rd_s) rd_a0_o <= a0_s;
    end
  end

  assign wr_done_o = wr_q & ~wr_s;
  assign rd_done_o = rd_q & ~rd_s;
endmodule

// File: rtl/host_mbox.sv
module host_mbox
  import host_mbox_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_cs_ni,
  input  logic          host_a0_i,
  input  logic          host_wr_ni,
  input  logic          host_rd_ni,
  input  logic [DW-1:0] host_d_i,
  output logic [DW-1:0] host_d_o,
  output logic          host_d_oe_o,
  input  logic          sl_re_i,
  input  logic          sl_we_i,
  input  logic [1:0]    sl_addr_i,
  input  logic [DW-1:0] sl_wdata_i,
  output logic [DW-1:0] sl_rdata_o,
  output logic          ibf_irq_o,
  output logic          obf_irq_o
);
  logic          wr_done, rd_done, wr_a0, rd_a0;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] idr_q, odr_q, status;
  logic          cd_q, ibf, obf;
  logic          ibf_set, ibf_clr, obf_set, obf_host_clr, obf_clr;

  mbox_host_if #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (host_cs_ni),
    .a0_i     (host_a0_i),
    .wr_ni    (host_wr_ni),
    .rd_ni    (host_rd_ni),
    .d_i      (host_d_i),
    .wr_done_o(wr_done),
    .rd_done_o(rd_done),
    .wr_data_o(wr_data),
    .wr_a0_o  (wr_a0),
    .rd_a0_o  (rd_a0)
  );

  assign ibf_set      = wr_done;
  assign ibf_clr      = sl_re_i && (sl_addr_i == SA_IDR);
  assign obf_set      = sl_we_i && (sl_addr_i == SA_ODR);
  assign obf_host_clr = rd_done && !rd_a0;
  assign obf_clr      = obf_host_clr || (sl_we_i && (sl_addr_i == SA_STS) && !sl_wdata_i[OBF_BIT]);

  mbox_flag u_ibf (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(ibf_set), .clr_i(ibf_clr), .q_o(ibf));
  mbox_flag u_obf (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(obf_set), .clr_i(obf_clr), .q_o(obf));

  // inbound byte has no defined reset value
  always_ff @(posedge clk_i) begin
    if (wr_done) idr_q <= wr_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odr_q <= '0;
      cd_q  <= 1'b0;
    end else begin
      if (obf_set) odr_q <= sl_wdata_i;
      if (wr_done) cd_q  <= wr_a0;
    end
  end

  always_comb begin
    status          = '0;
    status[OBF_BIT] = obf;
    status[IBF_BIT] = ibf;
    status[CD_BIT]  = cd_q;
  end

  always_comb begin
    unique case (sl_addr_i)
      SA_IDR:  sl_rdata_o = idr_q;
      SA_ODR:  sl_rdata_o = odr_q;
      SA_STS:  sl_rdata_o = status;
      default: sl_rdata_o = '0;
    endcase
  end

  assign host_d_o    = host_a0_i ? status : odr_q;
  assign host_d_oe_o = !host_cs_ni && !host_rd_ni;
  assign ibf_irq_o   = ibf;
  assign obf_irq_o   = obf;
endmodule

// File: rtl/host_mbox_chk.sv
module host_mbox_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sl_re_i,
  input logic          sl_we_i,
  input logic [1:0]    sl_addr_i,
  input logic [DW-1:0] sl_wdata_i,
  input logic          ibf_irq_o,
  input logic          obf_irq_o,
  input logic          ibf_set,
  input logic          obf_host_clr
);
  a_r4_ibf_rise_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ibf_irq_o) |-> $past(ibf_set));

  a_r5_ibf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_re_i && sl_addr_i == 2'd0 && !ibf_set) |=> !ibf_irq_o);

  a_r6_obf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_we_i && sl_addr_i == 2'd1) |=> obf_irq_o);

  a_r8_sts_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_we_i && sl_addr_i == 2'd2 && !sl_wdata_i[0]) |=> !obf_irq_o);

  a_r8_sts_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_we_i && sl_addr_i == 2'd2 && sl_wdata_i[0] && !obf_host_clr) |=> (obf_irq_o == $past(obf_irq_o)));

  a_r9_ibf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ibf_set |=> ibf_irq_o);
endmodule

bind host_mbox host_mbox_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sl_re_i     (sl_re_i),
  .sl_we_i     (sl_we_i),
  .sl_addr_i   (sl_addr_i),
  .sl_wdata_i  (sl_wdata_i),
  .ibf_irq_o   (ibf_irq_o),
  .obf_irq_o   (obf_irq_o),
  .ibf_set     (ibf_set),
  .obf_host_clr(obf_host_clr)
);

// File: tb/host_mbox_tb.sv
`timescale 1ns/1ps
module host_mbox_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, a0 = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] hd = 8'h00;
  logic [7:0] hq;
  logic       hoe;
  logic       sre = 1'b0, swe = 1'b0;
  logic [1:0] saddr = 2'd2;
  logic [7:0] swd = 8'h00;
  logic [7:0] srd;
  logic       ibf_irq, obf_irq;

  int vec = 0, bad = 0, cyc = 0;
  bit run = 0, done = 0;

  // reference model state
  logic [7:0] m_idr, m_odr;
  bit         m_idr_v, m_obf, m_ibf, m_cd;
  int         hw_tog = 0, hw_seen = 0, hw_cnt = 0;
  int         hr_tog = 0, hr_seen = 0, hr_cnt = 0;
  logic [7:0] hw_d;
  bit         hw_a0, hr_a0;

  always #4 clk = ~clk;

  host_mbox u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_cs_ni(cs_n), .host_a0_i(a0), .host_wr_ni(wr_n), .host_rd_ni(rd_n),
    .host_d_i(hd), .host_d_o(hq), .host_d_oe_o(hoe),
    .sl_re_i(sre), .sl_we_i(swe), .sl_addr_i(saddr), .sl_wdata_i(swd),
    .sl_rdata_o(srd), .ibf_irq_o(ibf_irq), .obf_irq_o(obf_irq)
  );

  function automatic logic [7:0] m_sts();
    return {4'b0, m_cd, 1'b0, m_ibf, m_obf};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_odr = 8'h00; m_obf = 0; m_ibf = 0; m_cd = 0; m_idr_v = 0;
      hw_cnt = 0; hr_cnt = 0; hw_seen = hw_tog; hr_seen = hr_tog;
    end else begin
      bit iset, iclr, oset, oclr;
      iset = 0; oclr = 0;
      if (hw_cnt != 0) begin
        hw_cnt--;
        if (hw_cnt == 0) iset = 1;
      end
      if (hr_cnt != 0) begin
        hr_cnt--;
        if (hr_cnt == 0 && !hr_a0) oclr = 1;
      end
      if (hw_tog != hw_seen) begin hw_seen = hw_tog; hw_cnt = 2; end
      if (hr_tog != hr_seen) begin hr_seen = hr_tog; hr_cnt = 2; end
      iclr = sre && saddr == 2'd0;
      oset = swe && saddr == 2'd1;
      if (swe && saddr == 2'd2 && !swd[0]) oclr = 1;
      if (iset) begin m_idr = hw_d; m_idr_v = 1; m_cd = hw_a0; end
      if (oset) m_odr = swd;
      m_ibf = iset ? 1'b1 : (iclr ? 1'b0 : m_ibf);
      m_obf = oset ? 1'b1 : (oclr ? 1'b0 : m_obf);
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run && rst_n) begin
      #1;
      chk("R4/R5/R11 ibf", {7'b0, ibf_irq}, {7'b0, m_ibf});
      chk("R6/R7/R11 obf", {7'b0, obf_irq}, {7'b0, m_obf});
      chk("R10 oe", {7'b0, hoe}, {7'b0, (!cs_n && !rd_n)});
      if (!cs_n && !rd_n) chk("R10 host data", hq, a0 ? m_sts() : m_odr);
      case (saddr)
        2'd0: if (m_idr_v) chk("R2 inbound byte", srd, m_idr);
        2'd1: chk("R6 outbound byte", srd, m_odr);
        2'd2: chk("R3 status", srd, m_sts());
        default: ;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic sl_op(bit we, bit re, logic [1:0] ad, logic [7:0] wd);
    swe = we; sre = re; saddr = ad; swd = wd;
    @(negedge clk);
    swe = 0; sre = 0; saddr = 2'd2;
  endtask

  // race=1: controller read of inbound byte on the edge the write lands
  task automatic host_wr(bit sel, bit ad, logic [7:0] d, bit race);
    cs_n = !sel; a0 = ad; hd = d; wr_n = 0;
    repeat (4) @(negedge clk);
    wr_n = 1; cs_n = 1;
    if (sel) begin hw_d = d; hw_a0 = ad; hw_tog++; end
    repeat (2) @(negedge clk);
    if (race) sl_op(0, 1, 2'd0, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  // race=1: controller outbound write on the edge the read lands
  task automatic host_rd(bit ad, bit race, logic [7:0] wd);
    cs_n = 0; a0 = ad; rd_n = 0;
    repeat (4) @(negedge clk);
    rd_n = 1; cs_n = 1;
    hr_a0 = ad; hr_tog++;
    repeat (2) @(negedge clk);
    if (race) sl_op(1, 0, 2'd1, wd);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    saddr = 2'd2; #1;
    chk("R1 status", srd, 8'h00);
    chk("R1 irqs", {6'b0, ibf_irq, obf_irq}, 8'h00);
    saddr = 2'd1; #1;
    chk("R1 outbound", srd, 8'h00);
    saddr = 2'd2;
    @(negedge clk);
    rst_n = 1;
    run = 1;
    repeat (2) @(negedge clk);

    host_wr(1, 0, 8'h5A, 0);            // R2 R4 data write
    sl_op(0, 1, 2'd0, 8'h00);           // R5
    host_wr(1, 1, 8'hC3, 0);            // R3 command tag
    host_wr(0, 0, 8'hFF, 0);            // R2 ignored without chip select
    sl_op(0, 0, 2'd0, 8'h00);
    sl_op(0, 1, 2'd0, 8'h00);
    host_wr(1, 0, 8'h11, 0);            // R4 overwrite
    host_wr(1, 1, 8'h22, 0);
    sl_op(0, 1, 2'd0, 8'h00);

    sl_op(1, 0, 2'd1, 8'h96);           // R6
    host_rd(1, 0, 8'h00);               // R7 status read keeps flag
    host_rd(0, 0, 8'h00);               // R7 outbound read clears
    sl_op(1, 0, 2'd1, 8'h3C);
    sl_op(1, 0, 2'd2, 8'h01);           // R8 keep
    sl_op(1, 0, 2'd2, 8'hFE);           // R8 clear

    host_wr(1, 1, 8'hA5, 1);            // R9 inbound set wins
    sl_op(0, 1, 2'd0, 8'h00);
    sl_op(1, 0, 2'd1, 8'h77);
    host_rd(0, 1, 8'h88);               // R9 outbound set wins
    sl_op(0, 0, 2'd1, 8'h00);
    sl_op(1, 0, 2'd2, 8'h00);

    for (int i = 0; i < 16; i++) begin
      host_wr(1, i[0], 8'(i * 37 + 5), i[2]);
      sl_op(0, 0, 2'd0, 8'h00);
      if (i[1]) sl_op(0, 1, 2'd0, 8'h00);
      sl_op(1, 0, 2'd1, 8'(i * 11));
      host_rd(i[0], i[3], 8'(i + 100));
      sl_op(0, 0, 2'd2, 8'h00);
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule